// File: doc/BRIEF.md
# Decode-Stage Equality Branch Resolver

This block settles conditional equality branches while they sit in the decode stage of a five-stage in-order pipeline. Fetch always runs ahead sequentially. The resolver computes the branch destination from the program counter and the immediate held in the fetch/decode register. It then compares the two source operands. When the branch is taken, it redirects fetch and clears the single younger instruction that was fetched on the wrong path.

An operand may still be in flight in a later stage. In that case the resolver takes it from the execute/memory or memory/writeback register instead of the register file. If the value cannot be obtained in time, it asks the pipeline to hold the branch in decode. An ALU result in execute holds the branch for one cycle, and a load in execute holds it for two. A load in the memory stage costs one cycle. The block is purely combinational. The surrounding hazard logic applies the stall and the flush at the next clock edge.

Top module: `id_branch_resolve`

## Requirements
- R1: `br_target` always equals `id_pc + 4 + (sign-extended id_imm << 2)`, modulo 2^XLEN, whether or not a branch is present.
- R2: For a resolved branch, `id_branch_ne=0` is taken when the two resolved operands are equal, and `id_branch_ne=1` is taken when they differ.
- R3: With `id_is_branch=0`, the outputs `br_taken`, `ifid_flush` and `id_stall` are all 0.
- R4: `ifid_flush` is 1 exactly when `br_taken` is 1.
- R5: A branch whose nonzero source register matches a writing instruction in execute (`ex_wr_en=1`, `ex_rd` equal) raises `id_stall` and is not taken. This holds for both load and ALU producers.
- R6: A branch whose nonzero source matches a writing load in the memory stage (`mem_wr_en=1`, `mem_is_load=1`) raises `id_stall` and is not taken.
- R7: A source that matches a writing non-load in the memory stage uses `mem_result` in place of the register-file value.
- R8: A source that matches a writing instruction in writeback, with no match in a nearer stage, uses `wb_data`.
- R9: When several stages match the same source, the nearest stage wins, in the order execute, then memory, then writeback.
- R10: Source register 0 never matches any stage and always uses its register-file value.
- R11: `id_stall` and `ifid_flush` are never 1 together. While the branch waits for an operand, no flush occurs.
- R12: A stage whose write-enable is 0 has no effect, even if its destination matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_is_branch | input | 1 | Decode holds a conditional equality branch |
| id_branch_ne | input | 1 | 0: branch on equal, 1: branch on not equal |
| id_pc | input | XLEN | PC of the branch in decode |
| id_imm | input | IMM_W | Word-offset immediate of the branch |
| id_rs | input | RA_W | First source register number |
| id_rt | input | RA_W | Second source register number |
| rf_rs_data | input | XLEN | Register-file value of first source |
| rf_rt_data | input | XLEN | Register-file value of second source |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | RA_W | Execute-stage destination register |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_rd | input | RA_W | Memory-stage destination register |
| mem_result | input | XLEN | ALU result held in the execute/memory register |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_rd | input | RA_W | Writeback-stage destination register |
| wb_data | input | XLEN | Value held in the memory/writeback register |
| br_target | output | XLEN | Branch destination address |
| br_taken | output | 1 | Redirect fetch to `br_target` |
| ifid_flush | output | 1 | Turn the fetch/decode register into a nop |
| id_stall | output | 1 | Hold the branch in decode this cycle |

## Verification
Every cycle, the assertions check several output properties. A non-branch never redirects, stalls or flushes. Flush tracks taken, and stall excludes flush. Any live match against execute, or against a load in memory, forces a stall. Only the bench's scenarios can show the following: the correct bypass value is selected and the nearest stage wins, register 0 is ignored, and the branch destination arithmetic with negative offsets is right. The bench also replays the cycle-by-cycle sequence in which a load advances from execute to memory to writeback, which gives two stall cycles and then a resolved branch.

// File: rtl/id_branch_resolve.sv
module id_branch_resolve #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int RA_W  = 5
) (
  input  logic            id_is_branch,
  input  logic            id_branch_ne,
  input  logic [XLEN-1:0] id_pc,
  input  logic [IMM_W-1:0] id_imm,
  input  logic [RA_W-1:0] id_rs,
  input  logic [RA_W-1:0] id_rt,
  input  logic [XLEN-1:0] rf_rs_data,
  input  logic [XLEN-1:0] rf_rt_data,
  input  logic            ex_wr_en,
  input  logic [RA_W-1:0] ex_rd,
  input  logic            mem_wr_en,
  input  logic            mem_is_load,
  input  logic [RA_W-1:0] mem_rd,
  input  logic [XLEN-1:0] mem_result,
  input  logic            wb_wr_en,
  input  logic [RA_W-1:0] wb_rd,
  input  logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] br_target,
  output logic            br_taken,
  output logic            ifid_flush,
  output logic            id_stall
);
  localparam int SHAMT = 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] imm_ext;
  assign imm_ext   = {{(XLEN-IMM_W){id_imm[IMM_W-1]}}, id_imm};
  assign br_target = id_pc + STEP + (imm_ext << SHAMT);

  logic [RA_W-1:0] src   [2];
  logic [XLEN-1:0] rfv   [2];
  logic [XLEN-1:0] opv   [2];
  logic [1:0]      hold;

  assign src[0] = id_rs;
  assign src[1] = id_rt;
  assign rfv[0] = rf_rs_data;
  assign rfv[1] = rf_rt_data;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic live, ex_m, mem_m, wb_m;
    assign live  = |src[g];
    assign ex_m  = live & ex_wr_en  & (ex_rd  == src[g]);
    assign mem_m = live & mem_wr_en & (mem_rd == src[g]);
    assign wb_m  = live & wb_wr_en  & (wb_rd  == src[g]);
    assign hold[g] = ex_m | (mem_m & mem_is_load);
    assign opv[g]  = mem_m ? mem_result : (wb_m ? wb_data : rfv[g]);
  end

  logic cond;
  assign cond       = (opv[0] == opv[1]) ^ id_branch_ne;
  assign id_stall   = id_is_branch & (|hold);
  assign br_taken   = id_is_branch & ~id_stall & cond;
  assign ifid_flush = br_taken;
endmodule

module id_branch_resolve_chk #(
  parameter int RA_W = 5
) (
  input logic            id_is_branch,
  input logic [RA_W-1:0] id_rs,
  input logic [RA_W-1:0] id_rt,
  input logic            ex_wr_en,
  input logic [RA_W-1:0] ex_rd,
  input logic            mem_wr_en,
  input logic            mem_is_load,
  input logic [RA_W-1:0] mem_rd,
  input logic            br_taken,
  input logic            ifid_flush,
  input logic            id_stall
);
  logic ex_dep, mem_ld_dep;
  assign ex_dep = ex_wr_en && ex_rd != '0 && (ex_rd == id_rs || ex_rd == id_rt);
  assign mem_ld_dep = mem_wr_en && mem_is_load && mem_rd != '0 &&
                      (mem_rd == id_rs || mem_rd == id_rt);

  always_comb begin
    a_r3_idle_quiet: assert (id_is_branch || (!br_taken && !ifid_flush && !id_stall))
      else $error("R3 violated");
    a_r4_flush_tracks_taken: assert (ifid_flush == br_taken)
      else $error("R4 violated");
    a_r11_no_stall_flush: assert (!(id_stall && ifid_flush))
      else $error("R11 violated");
    a_r5_ex_dep_stalls: assert (!(id_is_branch && ex_dep) || (id_stall && !br_taken))
      else $error("R5 violated");
    a_r6_mem_load_stalls: assert (!(id_is_branch && mem_ld_dep) || (id_stall && !br_taken))
      else $error("R6 violated");
  end
endmodule

bind id_branch_resolve id_branch_resolve_chk #(.RA_W(RA_W)) u_chk (
  .id_is_branch(id_is_branch), .id_rs(id_rs), .id_rt(id_rt),
  .ex_wr_en(ex_wr_en), .ex_rd(ex_rd),
  .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load), .mem_rd(mem_rd),
  .br_taken(br_taken), .ifid_flush(ifid_flush), .id_stall(id_stall)
);

// File: tb/id_branch_resolve_bench.sv
module id_branch_resolve_bench;
  logic clk = 0;
  always #2 clk = ~clk;

  logic        is_br, ne;
  logic [31:0] pc;
  logic [15:0] imm;
  logic [4:0]  rs, rt, exd, memd, wbd;
  logic [31:0] rfa, rfb, memr, wbv;
  logic        exw, memw, meml, wbw;
  logic [31:0] tgt;
  logic        taken, flush, stall;

  id_branch_resolve u_id_branch_resolve (
    .id_is_branch(is_br), .id_branch_ne(ne), .id_pc(pc), .id_imm(imm),
    .id_rs(rs), .id_rt(rt), .rf_rs_data(rfa), .rf_rt_data(rfb),
    .ex_wr_en(exw), .ex_rd(exd),
    .mem_wr_en(memw), .mem_is_load(meml), .mem_rd(memd), .mem_result(memr),
    .wb_wr_en(wbw), .wb_rd(wbd), .wb_data(wbv),
    .br_target(tgt), .br_taken(taken), .ifid_flush(flush), .id_stall(stall)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] e_target(logic [31:0] p, logic [15:0] i);
    return p + 32'd4 + {{14{i[15]}}, i, 2'b00};
  endfunction

  function automatic logic e_hold(logic [4:0] s);
    if (s == 0) return 0;
    if (exw && exd == s) return 1;
    if (memw && memd == s && meml) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] e_val(logic [4:0] s, logic [31:0] rf);
    if (s == 0) return rf;
    if (memw && memd == s) return memr;
    if (wbw && wbd == s) return wbv;
    return rf;
  endfunction

  task automatic check_all(string req);
    logic es, et;
    es = is_br && (e_hold(rs) || e_hold(rt));
    et = is_br && !es && ((e_val(rs, rfa) == e_val(rt, rfb)) != ne);
    chk({req, "/R1 target"}, tgt, e_target(pc, imm));
    chk({req, " stall"}, 32'(stall), 32'(es));
    chk({req, " taken"}, 32'(taken), 32'(et));
    chk({req, "/R4 flush"}, 32'(flush), 32'(et));
  endtask

  task automatic quiet();
    is_br = 0; ne = 0; pc = 0; imm = 0; rs = 0; rt = 0; rfa = 0; rfb = 0;
    exw = 0; exd = 0; memw = 0; meml = 0; memd = 0; memr = 0;
    wbw = 0; wbd = 0; wbv = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    quiet();
    @(negedge clk); #1;
    chk("R3 idle taken", 32'(taken), 0);
    chk("R3 idle stall", 32'(stall), 0);
    chk("R3 idle flush", 32'(flush), 0);

    @(negedge clk);
    pc = 32'h0000_1000; imm = 16'hFFFE; #1;
    chk("R1 negative offset", tgt, 32'h0000_0FFC);

    @(negedge clk);
    is_br = 1; rs = 3; rt = 4; rfa = 7; rfb = 7; #1;
    chk("R2 beq equal taken", 32'(taken), 1);
    chk("R4 flush on taken", 32'(flush), 1);
    @(negedge clk); ne = 1; #1;
    chk("R2 bne equal not taken", 32'(taken), 0);

    @(negedge clk); ne = 0; exw = 1; exd = 3; #1;
    chk("R5 alu in EX stalls", 32'(stall), 1);
    chk("R11 no flush while stalled", 32'(flush), 0);
    @(negedge clk); exw = 0; memw = 1; meml = 0; memd = 3; memr = 9; #1;
    chk("R7 alu in MEM forwarded", 32'(taken), 0);
    chk("R7 no stall", 32'(stall), 0);

    @(negedge clk); memw = 0; exw = 1; exd = 4; #1;
    chk("R5 load in EX cycle 1", 32'(stall), 1);
    @(negedge clk); exw = 0; memw = 1; meml = 1; memd = 4; #1;
    chk("R6 load in MEM cycle 2", 32'(stall), 1);
    @(negedge clk); memw = 0; meml = 0; wbw = 1; wbd = 4; wbv = 7; #1;
    chk("R8 load value from WB", 32'(taken), 1);
    chk("R8 resolved no stall", 32'(stall), 0);

    @(negedge clk); memw = 1; memd = 4; memr = 5; wbv = 7; #1;
    chk("R9 MEM beats WB", 32'(taken), 0);

    @(negedge clk); quiet(); is_br = 1; rs = 0; rt = 0; rfa = 2; rfb = 2;
    exw = 1; exd = 0; memw = 1; memd = 0; meml = 1; wbw = 1; wbd = 0; wbv = 1; #1;
    chk("R10 reg0 no stall", 32'(stall), 0);
    chk("R10 reg0 uses rf", 32'(taken), 1);

    @(negedge clk); quiet(); is_br = 1; rs = 6; rt = 7; rfa = 1; rfb = 1;
    exd = 6; memd = 7; memr = 3; meml = 1; wbd = 6; wbv = 8; #1;
    chk("R12 disabled stages ignored stall", 32'(stall), 0);
    chk("R12 disabled stages ignored taken", 32'(taken), 1);

    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      is_br = ($urandom % 4) != 0; ne = $urandom; pc = $urandom; imm = $urandom;
      rs = $urandom % 4; rt = $urandom % 4;
      rfa = $urandom % 3; rfb = $urandom % 3;
      exw = $urandom; exd = $urandom % 5;
      memw = $urandom; meml = $urandom; memd = $urandom % 5; memr = $urandom % 3;
      wbw = $urandom; wbd = $urandom % 5; wbv = $urandom % 3;
      #1;
      check_all("R2/R3/R5-R10 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule